// File: doc/BRIEF.md
# Pin Interrupt Sense and Flag Controller

This block turns eight external input pins into eight interrupt request lines. Software configures it through a small register bus. For each pin it picks one of several trigger conditions, and it keeps a sticky flag for edge-type events until software or the interrupt acknowledge clears it. A request line is raised only when that pin's enable bit is set and the global interrupt enable input is high.

Every pin passes through a synchronizer before any detection. The pin value is used whatever drives it, so firmware can toggle a pin it drives as an output and interrupt itself. The pins fall into two halves that decode the 2-bit sense field differently:

- Only the upper half can trigger on any change.
- On the lower half, code 01 means no trigger.

Low-level sensing drives the request straight from the synchronized pin and never sets the flag. Edge sensing sets the flag, and the flag drives the request.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset, the two sense registers, the enable register and the flag register all read 0, and every request line is 0. Every line therefore starts in low-level sense with its request disabled.
- R2: The bus decodes the register address as follows: address 0 is the sense register for lines 0-3, address 1 is the sense register for lines 4-7, address 2 is the enable mask, and address 3 is the flags. Line n uses bits [2(n mod 4)+1 : 2(n mod 4)] of its sense register. Writes to addresses 0-2 store the data, and read data returns the addressed register in the same cycle.
- R3: Sense code 00 (low level) holds the line's flag at 0. The request follows the synchronized pin being low, gated by the enable bit and the global enable.
- R4: Sense code 10 sets the flag on a falling edge between two successive synchronized samples. This holds on both halves. A low pulse lasting one clock period is caught.
- R5: Sense code 11 sets the flag on a rising edge between two successive synchronized samples, on both halves.
- R6: On lines 4-7, sense code 01 sets the flag on either edge.
- R7: On lines 0-3, sense code 01 sets no flag and raises no request.
- R8: With edge sense, request n equals flag n AND enable bit n AND the global enable. When the global enable is low, no request is raised, but flags still set.
- R9: A flag clears when 1 is written to its bit at address 3, or when its acknowledge bit is high. Writing 0 to a flag bit leaves it unchanged.
- R10: If an edge event and a clear (write or acknowledge) hit the same line in the same cycle, the flag ends up set.
- R11: A pin change reaches a low-level request two clock edges later, and reaches an edge flag three clock edges later.
- R12: A sense change made while the line is enabled is not filtered. Software disables the line, changes the sense, clears the flag by writing 1, and re-enables; after that the request stays low until a new qualifying edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | External pin levels (asynchronous) |
| gie_i | input | 1 | Global interrupt enable |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ack_i | input | 8 | Per-line interrupt acknowledge, clears flags |
| irq_o | output | 8 | Per-line interrupt request |

## Verification
Two functions can meet in one cycle: setting a flag from a detected edge, and clearing it through a flag write or an acknowledge. The bench provokes this by changing a pin and then placing a one-cycle write of 1 (in a second run, an acknowledge pulse) exactly in the cycle before the third clock edge, which is the edge that registers the event. The flag must then read 1. A clear issued one cycle later must read 0. This shows that the design prioritizes the set path on the edge where both paths are active, and does not merely order them in time.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_ALT  = 2'b01,
      SNS_FALL = 2'b10,
      SNS_RISE = 2'b11
   } sense_e;

   localparam int unsigned ADR_W = 2;

   localparam logic [ADR_W-1:0] ADR_SNS_LO = 2'd0;
   localparam logic [ADR_W-1:0] ADR_SNS_HI = 2'd1;
   localparam logic [ADR_W-1:0] ADR_MASK   = 2'd2;
   localparam logic [ADR_W-1:0] ADR_FLAG   = 2'd3;

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
   parameter int unsigned W       = 8,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stage_q [STAGES];

   initial begin
      assert (STAGES >= 2) else $fatal(1, "pirq_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{RST_VAL}};
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pirq_line.sv
module pirq_line
   import pirq_pkg::*;
#(
   parameter bit HAS_ANY = 1'b0
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   smp_i,
   input  sense_e sense_i,
   input  logic   clr_i,
   output logic   flag_o,
   output logic   low_o
);

   logic prev_q;
   logic flag_q;
   logic evt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= smp_i;
   end

   if (HAS_ANY) begin : g_any
      always_comb begin
         unique case (sense_i)
            SNS_ALT:  evt = prev_q ^ smp_i;
            SNS_FALL: evt = prev_q & ~smp_i;
            SNS_RISE: evt = ~prev_q & smp_i;
            default:  evt = 1'b0;
         endcase
      end

      // R6: either edge under code 01 sets the flag on the upper half
      a_r6_any_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sense_i == SNS_ALT && prev_q != smp_i) |=> flag_q);
   end else begin : g_plain
      always_comb begin
         unique case (sense_i)
            SNS_FALL: evt = prev_q & ~smp_i;
            SNS_RISE: evt = ~prev_q & smp_i;
            default:  evt = 1'b0;
         endcase
      end

      // R7: reserved code never raises a flag on the lower half
      a_r7_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sense_i == SNS_ALT && !flag_q) |=> !flag_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 flag_q <= 1'b0;
      else if (sense_i == SNS_LOW) flag_q <= 1'b0;
      else if (evt)                flag_q <= 1'b1;
      else if (clr_i)              flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign low_o  = (sense_i == SNS_LOW) & ~smp_i;

   a_r3_level_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i == SNS_LOW) |=> !flag_q);

   a_r4_fall_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i == SNS_FALL && prev_q && !smp_i) |=> flag_q);

   a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i != SNS_LOW && evt && clr_i) |=> flag_q);

   a_r9_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !evt) |=> !flag_q);

endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ADR_W-1:0] addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic             we_i,
   input  logic [DW-1:0]    flags_i,
   output logic [DW-1:0]    sns_lo_o,
   output logic [DW-1:0]    sns_hi_o,
   output logic [DW-1:0]    mask_o,
   output logic [DW-1:0]    flag_wclr_o,
   output logic [DW-1:0]    rdata_o
);

   logic [DW-1:0] sns_lo_q, sns_hi_q, mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sns_lo_q <= '0;
         sns_hi_q <= '0;
         mask_q   <= '0;
      end else if (we_i) begin
         if (addr_i == ADR_SNS_LO) sns_lo_q <= wdata_i;
         if (addr_i == ADR_SNS_HI) sns_hi_q <= wdata_i;
         if (addr_i == ADR_MASK)   mask_q   <= wdata_i;
      end
   end

   assign flag_wclr_o = (we_i && addr_i == ADR_FLAG) ? wdata_i : '0;

   always_comb begin
      unique case (addr_i)
         ADR_SNS_LO: rdata_o = sns_lo_q;
         ADR_SNS_HI: rdata_o = sns_hi_q;
         ADR_MASK:   rdata_o = mask_q;
         default:    rdata_o = flags_i;
      endcase
   end

   assign sns_lo_o = sns_lo_q;
   assign sns_hi_o = sns_hi_q;
   assign mask_o   = mask_q;

   a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADR_MASK) |=> (mask_o == $past(wdata_i)));

   a_r2_sense_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i) |=> ($stable(sns_lo_o) && $stable(sns_hi_o)));

endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
   import pirq_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DW-1:0]    pin_i,
   input  logic             gie_i,
   input  logic [ADR_W-1:0] addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic             we_i,
   output logic [DW-1:0]    rdata_o,
   input  logic [DW-1:0]    ack_i,
   output logic [DW-1:0]    irq_o
);

   localparam int unsigned HALF = DW / 2;

   initial begin
      assert (DW >= 2 && (DW % 2) == 0) else $fatal(1, "pirq_ctrl: DW must be even and at least 2");
   end

   logic [DW-1:0] smp, flags, low, clr;
   logic [DW-1:0] sns_lo, sns_hi, mask, flag_wclr;

   pirq_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (smp)
   );

   pirq_regs #(.DW(DW)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .we_i       (we_i),
      .flags_i    (flags),
      .sns_lo_o   (sns_lo),
      .sns_hi_o   (sns_hi),
      .mask_o     (mask),
      .flag_wclr_o(flag_wclr),
      .rdata_o    (rdata_o)
   );

   assign clr = flag_wclr | ack_i;

   for (genvar n = 0; n < DW; n++) begin : g_line
      localparam int unsigned FLD = n % HALF;
      localparam bit UPPER = (n >= HALF);
      logic [1:0] sns_bits;

      if (UPPER) begin : g_hi
         assign sns_bits = sns_hi[2*FLD +: 2];
      end else begin : g_lo
         assign sns_bits = sns_lo[2*FLD +: 2];
      end

      pirq_line #(.HAS_ANY(UPPER)) u_line (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .smp_i  (smp[n]),
         .sense_i(sense_e'(sns_bits)),
         .clr_i  (clr[n]),
         .flag_o (flags[n]),
         .low_o  (low[n])
      );

      // R3: a low synchronized pin in level mode raises the enabled request
      a_r3_level_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sns_bits == 2'b00 && !smp[n] && mask[n] && gie_i) |-> irq_o[n]);
   end

   assign irq_o = mask & {DW{gie_i}} & (flags | low);

   a_r8_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!gie_i) |-> (irq_o == '0));

   a_r8_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_o & ~mask) == '0));

endmodule

// File: tb/tb_pirq_ctrl.sv
module tb_pirq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin = 8'hFF;
   logic       gie = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic       we = 1'b0;
   logic [7:0] ack = 8'h00;
   logic [7:0] rdata, irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pirq_ctrl dut (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .pin_i  (pin),
      .gie_i  (gie),
      .addr_i (addr),
      .wdata_i(wdata),
      .we_i   (we),
      .rdata_o(rdata),
      .ack_i  (ack),
      .irq_o  (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      rd_chk(2'd0, 8'h00, "R1 sense lo");
      rd_chk(2'd1, 8'h00, "R1 sense hi");
      rd_chk(2'd2, 8'h00, "R1 mask");
      rd_chk(2'd3, 8'h00, "R1 flags");
      chk("R1 irq", irq, 8'h00);

      // R2: register write and readback
      wr(2'd0, 8'hA4); wr(2'd1, 8'h3C); wr(2'd2, 8'h5A);
      rd_chk(2'd0, 8'hA4, "R2 sense lo");
      rd_chk(2'd1, 8'h3C, "R2 sense hi");
      rd_chk(2'd2, 8'h5A, "R2 mask");
      wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'hFF);
      gie = 1'b1;

      // Sweep: every line, every sense code, both edges
      for (int i = 0; i < 8; i++) begin
         for (int m = 0; m < 4; m++) begin
            logic [7:0] fld;
            logic ef, er;
            string tag;
            fld = 8'(m << (2 * (i % 4)));
            if (m == 0) tag = "R3";
            else if (m == 1) tag = (i >= 4) ? "R6" : "R7";
            else if (m == 2) tag = "R4";
            else tag = "R5";
            wr(2'd2, 8'h00);
            wr(2'd0, (i < 4) ? fld : 8'h00);
            wr(2'd1, (i >= 4) ? fld : 8'h00);
            wr(2'd3, 8'hFF);
            wr(2'd2, 8'(1 << i));
            ef = (m == 2) || (m == 1 && i >= 4);
            er = (m == 3) || (m == 1 && i >= 4);
            @(negedge clk); pin[i] = 1'b0;
            settle();
            rd_chk(2'd3, 8'(ef << i), {tag, " flag after fall"});
            chk({tag, " irq after fall"}, irq, 8'(((m == 0) ? 1'b1 : ef) << i));
            wr(2'd3, 8'hFF);
            @(negedge clk); pin[i] = 1'b1;
            settle();
            rd_chk(2'd3, 8'(er << i), {tag, " flag after rise"});
            chk({tag, " irq after rise"}, irq, 8'(er << i));
            wr(2'd3, 8'hFF);
         end
      end
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

      // R11: latency, line 0 level then line 3 falling edge
      wr(2'd2, 8'h01);
      @(negedge clk); pin[0] = 1'b0;
      @(negedge clk); #1; chk("R11 level after 1 edge", irq, 8'h00);
      @(negedge clk); #1; chk("R11 level after 2 edges", irq, 8'h01);
      @(negedge clk); pin[0] = 1'b1;
      wr(2'd0, 8'h80); wr(2'd2, 8'h08);
      @(negedge clk); pin[3] = 1'b0;
      @(negedge clk);
      @(negedge clk); #1; rd_chk(2'd3, 8'h00, "R11 edge after 2 edges");
      @(negedge clk); #1; rd_chk(2'd3, 8'h08, "R11 edge after 3 edges");
      @(negedge clk); pin[3] = 1'b1;
      wr(2'd3, 8'hFF);

      // R4: one-cycle low pulse on line 5, falling sense
      wr(2'd1, 8'h08); wr(2'd2, 8'h20);
      @(negedge clk); pin[5] = 1'b0;
      @(negedge clk); pin[5] = 1'b1;
      settle();
      rd_chk(2'd3, 8'h20, "R4 short pulse");
      wr(2'd3, 8'hFF);

      // R10: set and write-clear in same cycle, line 1 falling
      wr(2'd1, 8'h00); wr(2'd0, 8'h08); wr(2'd2, 8'h02);
      @(negedge clk); pin[1] = 1'b0;
      @(negedge clk);
      @(negedge clk); addr = 2'd3; wdata = 8'h02; we = 1'b1;
      @(negedge clk); we = 1'b0;
      #1; rd_chk(2'd3, 8'h02, "R10 set beats write clear");
      // R9: write 0 keeps, write 1 clears
      wr(2'd3, 8'h00);
      #1; rd_chk(2'd3, 8'h02, "R9 write zero no effect");
      wr(2'd3, 8'h02);
      #1; rd_chk(2'd3, 8'h00, "R9 write one clears");
      @(negedge clk); pin[1] = 1'b1;
      settle();
      // R10: set and acknowledge in same cycle
      @(negedge clk); pin[1] = 1'b0;
      @(negedge clk);
      @(negedge clk); ack = 8'h02;
      @(negedge clk); ack = 8'h00;
      #1; rd_chk(2'd3, 8'h02, "R10 set beats ack");
      @(negedge clk); ack = 8'h02;
      @(negedge clk); ack = 8'h00;
      #1; rd_chk(2'd3, 8'h00, "R9 ack clears");
      @(negedge clk); pin[1] = 1'b1;
      settle();

      // R8: global enable gating on line 4, rising sense
      wr(2'd0, 8'h00); wr(2'd1, 8'h03); wr(2'd2, 8'h10);
      gie = 1'b0;
      @(negedge clk); pin[4] = 1'b0;
      settle();
      @(negedge clk); pin[4] = 1'b1;
      settle();
      rd_chk(2'd3, 8'h10, "R8 flag sets with gie low");
      chk("R8 irq held by gie", irq, 8'h00);
      gie = 1'b1; #1;
      chk("R8 irq with gie", irq, 8'h10);
      wr(2'd2, 8'h00); #1;
      chk("R8 irq masked", irq, 8'h00);
      wr(2'd3, 8'hFF);

      // R12: sense change procedure on line 2
      wr(2'd1, 8'h00); wr(2'd0, 8'h20); wr(2'd2, 8'h04);
      @(negedge clk); pin[2] = 1'b0;
      settle();
      chk("R12 falling request", irq, 8'h04);
      wr(2'd2, 8'h00); wr(2'd0, 8'h30); wr(2'd3, 8'h04); wr(2'd2, 8'h04);
      settle();
      chk("R12 quiet after re-enable", irq, 8'h00);
      rd_chk(2'd3, 8'h00, "R12 flag clean");
      @(negedge clk); pin[2] = 1'b1;
      settle();
      chk("R12 rising request", irq, 8'h04);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule